// File: doc/BRIEF.md
# Two-Factor Bit-Rate Strobe Generator for an I2C Master

This block derives the bit timing of an I2C master from a fast system clock. A 7-bit rate word holds two fields: an exponent field that selects a power-of-two prescaler and a linear field that selects a small integer divider. Each SCL period is cut into ten equal sub-phases. The block emits a one-cycle strobe at the start of every sub-phase, together with the index of the sub-phase now in progress. The bit engine next to it uses that index to place the SCL edges, the SDA setup point and the SDA sample point.

Three counters run in cascade. The prescaler produces one pulse every 2^(e+K) system clocks, where `e` is the exponent field and `K` is a build-time offset of 1 (default) or 0. The linear divider turns every `l+1` of those pulses into a sub-phase strobe, where `l` is the linear field. A modulo-ten counter then steps the phase index. Software picks the two fields for its target rate.

While the block is enabled, a new rate word waits in a shadow register and is applied only when the index wraps from 9 to 0, so an SCL period in progress is never stretched or cut. While the block is disabled, every counter is held at zero and the rate word passes straight through, so the first period after enabling starts at index 0 with the latest value.

Top module: `scl_rate_gen`

## Requirements
- R1: After the synchronous reset, the rate word is 0x44 (linear field 8, exponent field 4). While reset is held, `phase_tick` is 0 and `phase_idx` is 0.
- R2: The rate word places the exponent field `e` in bits [2:0] and the linear field `l` in bits [6:3]. With the default offset, strobes are spaced (l+1)·2^(e+1) system clocks apart, so one SCL period lasts 10·(l+1)·2^(e+1) clocks.
- R3: Each strobe advances `phase_idx` by one, counting 0 to 9 and then wrapping to 0. When `phase_tick` is high, `phase_idx` already shows the new value.
- R4: When the block is built with `EXP_OFFSET` = 0, strobes are spaced (l+1)·2^e system clocks apart.
- R5: In the cycle after `enable` is sampled low, `phase_tick` is 0 and `phase_idx` is 0, and both stay there while `enable` stays low. After `enable` is sampled high, the first strobe comes exactly one strobe spacing later, counted in rising edges from the first edge that sees `enable` high.
- R6: A rate word written while the block is enabled does not change the current period. Every strobe up to and including the one that wraps the index to 0 keeps the old spacing, and the strobes after it use the new spacing.
- R7: A rate word written while the block is disabled sets the spacing of the first period after enabling.
- R8: A one-cycle `soft_rst` reloads the rate word with 0x44 and clears the phase and all counters. The first strobe then follows after 288 system clocks, or 144 when built with `EXP_OFFSET` = 0.
- R9: When the strobe spacing is two or more clocks, `phase_tick` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the counters when high; clears them when low |
| soft_rst | input | 1 | Reloads the default rate word and clears the counters |
| baud_wr | input | 1 | Write strobe for the rate word |
| baud_wdata | input | 7 | Rate word: exponent field in [2:0], linear field in [6:3] |
| phase_tick | output | 1 | One-cycle strobe at the start of each sub-phase |
| phase_idx | output | $clog2(PHASES) | Index of the current sub-phase, 0 to 9 |

## Verification
The bench builds two copies of the block. One uses the default exponent offset of 1. The other uses an offset of 0, so the power-of-two prescaler can collapse to a single clock and the strobe spacing can fall to one clock. With the fixed 7-bit rate word, each copy is small enough to sweep all 128 rate words. The bench measures the first-strobe delay for every word, which covers all prescaler and divider terminal counts in both variants. It also runs directed checks on the shadow-then-wrap update, on disabling in mid-period, and on the soft reset.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
  // Field widths of the rate word; the bit layout is visible to software.
  localparam int unsigned EXP_FIELD_W = 3;
  localparam int unsigned LIN_FIELD_W = 4;
  localparam int unsigned BAUD_W      = EXP_FIELD_W + LIN_FIELD_W;

  // Linear field in the upper bits, exponent field in the lower bits.
  typedef struct packed {
    logic [LIN_FIELD_W-1:0] lin;
    logic [EXP_FIELD_W-1:0] expo;
  } baud_t;

  // Power-on rate word 0x44: linear 8, exponent 4.
  localparam baud_t BAUD_POR = '{lin: 4'd8, expo: 3'd4};
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned N_W        = 3,
  parameter int unsigned EXP_OFFSET = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic [N_W-1:0] expo,
  output logic           pulse
);
  localparam int unsigned PRE_W = (1 << N_W) - 1 + EXP_OFFSET;

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] term;

  // Terminal count 2^(expo+EXP_OFFSET)-1: the low (expo+EXP_OFFSET) bits are set.
  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      term[i] = (i < (int'(expo) + int'(EXP_OFFSET)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt == term) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign pulse = !rst && !clr && (cnt == term);

  // R2: the count never passes the terminal value of the active exponent.
  a_r2_pre_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= term);
endmodule

// File: rtl/scl_lin_div.sv
module scl_lin_div #(
  parameter int unsigned M_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           step,
  input  logic [M_W-1:0] lin,
  output logic           strobe
);
  logic [M_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (step) begin
      if (cnt == lin) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign strobe = step && (cnt == lin);

  // R2: the linear count stays within 0..lin.
  a_r2_lin_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= lin);

  // R2: the linear count moves only on a prescaler pulse.
  a_r2_lin_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(cnt));
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int unsigned PHASES = 10,
  localparam int unsigned PH_W  = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            adv,
  output logic [PH_W-1:0] phase,
  output logic            wrap
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase <= '0;
    end else if (adv) begin
      if (phase == LAST) begin
        phase <= '0;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign wrap = adv && (phase == LAST);

  // R3: the index never leaves 0..PHASES-1.
  a_r3_phase_range: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);

  // R3: each advance steps the index by one, wrapping after the last phase.
  a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr) |=> (phase == (($past(phase) == LAST) ? '0 : $past(phase) + 1'b1)));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int unsigned EXP_OFFSET = 1,
  parameter int unsigned PHASES     = 10,
  parameter baud_t       RESET_BAUD = BAUD_POR,
  localparam int unsigned PH_W      = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              soft_rst,
  input  logic              baud_wr,
  input  logic [BAUD_W-1:0] baud_wdata,
  output logic              phase_tick,
  output logic [PH_W-1:0]   phase_idx
);
  baud_t shadow_q;
  baud_t active_q;
  logic  clr;
  logic  pre_pulse;
  logic  sub_strobe;
  logic  wrap;

  assign clr = !enable || soft_rst;

  // Staging register: takes every write at once.
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      shadow_q <= RESET_BAUD;
    end else if (baud_wr) begin
      shadow_q <= baud_t'(baud_wdata);
    end
  end

  // Working rate word: follows the shadow while disabled, else only at a wrap.
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      active_q <= RESET_BAUD;
    end else if (!enable || wrap) begin
      active_q <= shadow_q;
    end
  end

  scl_prescaler #(
    .N_W       (EXP_FIELD_W),
    .EXP_OFFSET(EXP_OFFSET)
  ) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .expo (active_q.expo),
    .pulse(pre_pulse)
  );

  scl_lin_div #(
    .M_W(LIN_FIELD_W)
  ) u_lin (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .step  (pre_pulse),
    .lin   (active_q.lin),
    .strobe(sub_strobe)
  );

  scl_phase_ctr #(
    .PHASES(PHASES)
  ) u_phase (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .adv  (sub_strobe),
    .phase(phase_idx),
    .wrap (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase_tick <= 1'b0;
    end else begin
      phase_tick <= sub_strobe;
    end
  end

  // R6: while running, the working rate word changes only at a 9->0 wrap.
  a_r6_hold_rate: assert property (@(posedge clk) disable iff (rst)
    (enable && !soft_rst && !wrap) |=> $stable(active_q));

  // R5: a disable leaves the outputs idle in the next cycle.
  a_r5_idle: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (phase_idx == '0 && !phase_tick));

  // R8: a soft reset restores the default word and the first phase.
  a_r8_soft: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (active_q == RESET_BAUD && phase_idx == '0 && !phase_tick));

  // R3: the strobe and the index change move together.
  a_r3_tick_moves_idx: assert property (@(posedge clk) disable iff (rst)
    phase_tick |-> (phase_idx != $past(phase_idx)));

  generate
    if (EXP_OFFSET > 0) begin : g_pulse_chk
      // R9: with a spacing of at least two clocks, the strobe is one cycle wide.
      a_r9_single: assert property (@(posedge clk) disable iff (rst)
        phase_tick |=> !phase_tick);
    end
  endgenerate
endmodule

// File: tb/scl_rate_gen_tb.sv
module scl_rate_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b1, srst = 1'b0, wr = 1'b0;
  logic [6:0] wdata = '0;
  logic       tick;
  logic [3:0] phase;
  logic       en2 = 1'b0, wr2 = 1'b0;
  logic [6:0] wdata2 = '0;
  logic       tick2;
  logic [3:0] phase2;
  logic       zero = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_rate_gen u_dut (
    .clk(clk), .rst(rst), .enable(en), .soft_rst(srst),
    .baud_wr(wr), .baud_wdata(wdata), .phase_tick(tick), .phase_idx(phase)
  );

  scl_rate_gen #(.EXP_OFFSET(0)) u_dut_alt (
    .clk(clk), .rst(rst), .enable(en2), .soft_rst(zero),
    .baud_wr(wr2), .baud_wdata(wdata2), .phase_tick(tick2), .phase_idx(phase2)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts rising edges from the current falling edge until a strobe is seen.
  task automatic wait_strobe(input bit alt, output int edges);
    edges = -1;
    for (int k = 1; k <= 5000; k++) begin
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0;
      wr2 = 1'b0;
      if ((alt ? tick2 : tick) === 1'b1) begin
        edges = k;
        break;
      end
    end
  endtask

  task automatic load_disabled(input bit alt, input logic [6:0] v);
    if (alt) begin en2 = 1'b0; wr2 = 1'b1; wdata2 = v; end
    else begin en = 1'b0; wr = 1'b1; wdata = v; end
    @(negedge clk);
    wr = 1'b0; wr2 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (alt) en2 = 1'b1; else en = 1'b1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e;
    int exp_d;
    repeat (3) @(negedge clk);
    // R1: idle outputs while reset is held
    check(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
    check(phase == 4'd0, "R1 phase in reset", int'(phase), 0);
    rst = 1'b0;
    // R1: default word 0x44 -> 9*32 = 288 clocks per strobe
    wait_strobe(1'b0, e);
    check(e == 288, "R1 default spacing", e, 288);
    check(phase == 4'd1, "R1 first index", int'(phase), 1);

    // R3: word 0 -> spacing 2; index counts through 1..9,0 twice
    load_disabled(1'b0, 7'h00);
    for (int k = 1; k <= 20; k++) begin
      wait_strobe(1'b0, e);
      check(e == 2, "R3 spacing", e, 2);
      check(int'(phase) == k % 10, "R3 index step", int'(phase), k % 10);
    end
    @(negedge clk);
    // R9: strobe lasted a single cycle
    check(tick == 1'b0, "R9 single cycle", int'(tick), 0);

    // R6: run at 0x08 (spacing 4), write 0x11 (spacing 12) at index 3
    load_disabled(1'b0, 7'h08);
    for (int k = 1; k <= 3; k++) wait_strobe(1'b0, e);
    wr = 1'b1; wdata = 7'h11;
    for (int k = 4; k <= 10; k++) begin
      wait_strobe(1'b0, e);
      check(e == 4, "R6 old spacing kept", e, 4);
    end
    check(phase == 4'd0, "R6 wrapped", int'(phase), 0);
    for (int k = 1; k <= 2; k++) begin
      wait_strobe(1'b0, e);
      check(e == 12, "R6 new spacing", e, 12);
    end

    // R5: disable in mid-period
    en = 1'b0;
    @(negedge clk);
    check(phase == 4'd0 && tick == 1'b0, "R5 idle after disable", int'(phase), 0);
    repeat (5) @(negedge clk);
    check(phase == 4'd0 && tick == 1'b0, "R5 idle held", int'(phase), 0);
    // R7: word written while disabled, 0x3A -> 8*8 = 64
    load_disabled(1'b0, 7'h3A);
    wait_strobe(1'b0, e);
    check(e == 64, "R7 write while disabled", e, 64);
    wait_strobe(1'b0, e);

    // R8: soft reset reloads 0x44
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
    check(phase == 4'd0 && tick == 1'b0, "R8 cleared", int'(phase), 0);
    wait_strobe(1'b0, e);
    check(e == 288, "R8 default after soft reset", e, 288);

    // R2 / R5: sweep all words; first strobe after enable at (l+1)*2^(e+1)
    for (int v = 0; v < 128; v++) begin
      exp_d = ((v >> 3) + 1) << ((v & 7) + 1);
      load_disabled(1'b0, 7'(v));
      wait_strobe(1'b0, e);
      check(e == exp_d, $sformatf("R2 sweep word %0d", v), e, exp_d);
      check(phase == 4'd1, "R5 first index", int'(phase), 1);
    end

    // R4: offset-0 variant sweep, spacing (l+1)*2^e
    for (int v = 0; v < 128; v++) begin
      exp_d = ((v >> 3) + 1) << (v & 7);
      load_disabled(1'b1, 7'(v));
      wait_strobe(1'b1, e);
      check(e == exp_d, $sformatf("R4 sweep word %0d", v), e, exp_d);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule